// File: doc/BRIEF.md
# Queue-Status Interrupt Register Block

This block is the host-facing register set of a two-port channel controller. Software reaches it over a plain 32-bit register bus. Each access carries a write strobe or a read strobe, a byte address and write data, and read data returns one cycle later with a valid flag.

Four registers are held here:
- a configuration word whose fields drive the controller's burst size and bus options;
- a sticky error word that hardware error strobes set and software clears bit by bit;
- a command/status word that reflects live queue status and requests a soft reset;
- an interrupt enable word.

The interrupt output folds the queue status into one line, and the two queue directions use opposite polarity. A response queue asks for service while its status bit is 1. A request queue asks for service while its status bit is 0, which means it has drained. Error and non-queued events join the same line. Every source is gated by its enable bit before the OR.

Top module: `qsirq_regblk`

## Requirements
- R1: After reset, every register reads 0, the interrupt output and the soft-reset pulse are low, read-valid is low and the configuration outputs are 0.
- R2: A read strobe returns the addressed word on reg_rdata, with reg_rvalid high, for exactly one cycle after the strobe edge. Word offsets are 0x0 for configuration, 0x4 for errors, 0x8 for command/status and 0xC for enables. An access whose two low address bits are not 00 writes nothing and reads 0.
- R3: The configuration word holds its burst code in bits 2:0, enhanced bus mode in bit 3, parity checking in bit 4 and parity test in bit 5. The configuration outputs follow it from the cycle after a write, and bits 31:6 read 0.
- R4: Only the burst codes 0, 4, 5 and 6 (4, 16, 32 and 64 byte bursts) are stored. A write carrying any other code leaves the burst field unchanged but still updates bits 5:3.
- R5: Error bits are sticky: bit 2 is misalignment, bit 1 is an unsupported access and bit 0 is parity. Each is set by a one-cycle strobe and is cleared by writing 1 to it at offset 0x4. A strobe in the same cycle as a clear of that bit leaves the bit set.
- R6: Command/status reads back response-queue status 3..0 in bits 19:16 and request-queue status 3..0 in bits 11:8. Bit 7 is the OR of the error bits, bit 3 is interrupt pending, bit 2 is the non-queued input and bit 1 is the idle input. All other bits, including bit 0, read 0.
- R7: In the enable word, only bits 19:16, 11:8, 7 and 2 are writable. All other bits read 0.
- R8: The interrupt output is registered. It equals the OR of four terms, each gated by its enable bit: (response status), (inverted request status), (any error) and (non-queued). It follows its sources one cycle later, and the pending bit in command/status reads the same value.
- R9: An enabled request queue drives the interrupt while its status bit is 0 and stops driving it while the bit is 1. An enabled response queue does the reverse.
- R10: Writing 1 to command/status bit 0 raises the soft-reset output for exactly one cycle, starting the cycle after the write. At the end of that cycle the error and enable words clear, and configuration is kept. A request written while the pulse is high is ignored.
- R11: Writing to command/status bits other than bit 0 has no effect on any register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| rspq_stat | input | NQ | Response-queue status, 1 = needs service |
| reqq_stat | input | NQ | Request-queue status, 0 = needs service |
| nonq_stat | input | 1 | Non-queued event status |
| idle_stat | input | 1 | Controller idle status |
| err_align | input | 1 | Misaligned-access error strobe |
| err_unsup | input | 1 | Unsupported-access error strobe |
| err_parity | input | 1 | Parity error strobe |
| irq | output | 1 | Masked interrupt request |
| soft_rst_pulse | output | 1 | One-cycle soft-reset pulse |
| cfg_burst | output | 3 | Stored burst code |
| cfg_enh_mode | output | 1 | Enhanced bus mode enable |
| cfg_par_check | output | 1 | Parity check enable |
| cfg_par_test | output | 1 | Parity test enable |

## Verification
Results fall due at different times after a stimulus:
- Read data and the register-driven outputs appear one edge after the strobe.
- The interrupt line moves one edge after a status input changes, and two edges after an enable or error write, because the write first updates a register that the interrupt register then samples.
- The soft-reset pulse appears one edge after its write, and the words it clears read 0 from the edge after that.

The bench drives inputs and samples outputs on the falling edge. Its read task idles one cycle before issuing the strobe, so the pending bit has settled when it is sampled. Each expected read value is queued when the strobe is driven and is compared by a monitor when reg_rvalid rises.

// File: rtl/qsirq_pkg.sv
package qsirq_pkg;

    localparam int unsigned DW = 32;

    // word indices (byte offset >> 2)
    localparam int unsigned IDX_CFG = 0;
    localparam int unsigned IDX_ERR = 1;
    localparam int unsigned IDX_CMD = 2;
    localparam int unsigned IDX_MSK = 3;

    // command/status and enable word positions
    localparam int unsigned RSP_LSB  = 16;
    localparam int unsigned REQ_LSB  = 8;
    localparam int unsigned CMD_SAE  = 7;
    localparam int unsigned CMD_PEND = 3;
    localparam int unsigned CMD_NONQ = 2;
    localparam int unsigned CMD_IDLE = 1;
    localparam int unsigned CMD_SRST = 0;

    // error word
    localparam int unsigned NERR      = 3;
    localparam int unsigned ERR_PAR   = 0;
    localparam int unsigned ERR_UNSUP = 1;
    localparam int unsigned ERR_ALIGN = 2;

    localparam int unsigned CFG_W = 6;

    typedef struct packed {
        logic       par_test;
        logic       par_check;
        logic       enh_mode;
        logic [2:0] burst;
    } cfg_t;

    function automatic logic burst_ok(input logic [2:0] code);
        return (code == 3'd0) || (code == 3'd4) || (code == 3'd5) || (code == 3'd6);
    endfunction

endpackage

// File: rtl/qsirq_cfg_reg.sv
module qsirq_cfg_reg
    import qsirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg
);

    cfg_t cfg_d, cfg_q;
    cfg_t wr_view;

    always_comb begin
        wr_view = cfg_t'(wdata);
        cfg_d   = cfg_q;
        if (wr_en) begin
            cfg_d.par_test  = wr_view.par_test;
            cfg_d.par_check = wr_view.par_check;
            cfg_d.enh_mode  = wr_view.enh_mode;
            if (burst_ok(wr_view.burst)) begin
                cfg_d.burst = wr_view.burst;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/qsirq_err_reg.sv
module qsirq_err_reg
    import qsirq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_all,
    input  logic [NERR-1:0] set_stb,
    input  logic            w1c_en,
    input  logic [NERR-1:0] w1c_bits,
    output logic [NERR-1:0] err
);

    logic [NERR-1:0] err_d, err_q;

    always_comb begin
        err_d = err_q;
        for (int i = 0; i < NERR; i++) begin
            if (clr_all) begin
                err_d[i] = 1'b0;
            end else if (set_stb[i]) begin
                err_d[i] = 1'b1;
            end else if (w1c_en && w1c_bits[i]) begin
                err_d[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= '0;
        end else begin
            err_q <= err_d;
        end
    end

    assign err = err_q;

endmodule

// File: rtl/qsirq_irq_vec.sv
module qsirq_irq_vec #(
    parameter int unsigned NQ = 4
) (
    input  logic [NQ-1:0] rsp_stat,
    input  logic [NQ-1:0] rsp_msk,
    input  logic [NQ-1:0] req_stat,
    input  logic [NQ-1:0] req_msk,
    input  logic          err_any,
    input  logic          err_msk,
    input  logic          nonq,
    input  logic          nonq_msk,
    output logic          irq_any
);

    logic [NQ-1:0] rsp_hit;
    logic [NQ-1:0] req_hit;

    for (genvar q = 0; q < NQ; q++) begin : g_queue
        assign rsp_hit[q] = rsp_stat[q] & rsp_msk[q];
        assign req_hit[q] = ~req_stat[q] & req_msk[q];
    end

    assign irq_any = (|rsp_hit) | (|req_hit) | (err_any & err_msk) | (nonq & nonq_msk);

endmodule

// File: rtl/qsirq_regblk.sv
module qsirq_regblk
    import qsirq_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned NQ     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_rvalid,
    input  logic [NQ-1:0]     rspq_stat,
    input  logic [NQ-1:0]     reqq_stat,
    input  logic              nonq_stat,
    input  logic              idle_stat,
    input  logic              err_align,
    input  logic              err_unsup,
    input  logic              err_parity,
    output logic              irq,
    output logic              soft_rst_pulse,
    output logic [2:0]        cfg_burst,
    output logic              cfg_enh_mode,
    output logic              cfg_par_check,
    output logic              cfg_par_test
);

    localparam int unsigned   WIDX_W  = ADDR_W - 2;
    localparam logic [DW-1:0] QONES   = DW'((33'd1 << NQ) - 33'd1);
    localparam logic [DW-1:0] MASK_WR = (QONES << RSP_LSB) | (QONES << REQ_LSB)
                                      | (DW'(1) << CMD_SAE) | (DW'(1) << CMD_NONQ);

    typedef struct packed {
        logic [DW-1:0] mask;
        logic          srst;
        logic          irq;
        logic [DW-1:0] rdata;
        logic          rvalid;
    } blk_st_t;

    blk_st_t s_d, s_q;

    // address decode
    logic              aligned;
    logic [WIDX_W-1:0] widx;
    logic              hit_cfg, hit_err, hit_cmd, hit_msk;

    assign aligned = (reg_addr[1:0] == 2'b00);
    assign widx    = reg_addr[ADDR_W-1:2];
    assign hit_cfg = aligned && (widx == WIDX_W'(IDX_CFG));
    assign hit_err = aligned && (widx == WIDX_W'(IDX_ERR));
    assign hit_cmd = aligned && (widx == WIDX_W'(IDX_CMD));
    assign hit_msk = aligned && (widx == WIDX_W'(IDX_MSK));

    // configuration word
    cfg_t cfg;

    qsirq_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr && hit_cfg),
        .wdata (reg_wdata[CFG_W-1:0]),
        .cfg   (cfg)
    );

    // sticky errors
    logic [NERR-1:0] err_bits;
    logic [NERR-1:0] err_set;

    always_comb begin
        err_set            = '0;
        err_set[ERR_PAR]   = err_parity;
        err_set[ERR_UNSUP] = err_unsup;
        err_set[ERR_ALIGN] = err_align;
    end

    qsirq_err_reg u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (s_q.srst),
        .set_stb  (err_set),
        .w1c_en   (reg_wr && hit_err),
        .w1c_bits (reg_wdata[NERR-1:0]),
        .err      (err_bits)
    );

    // interrupt combine
    logic irq_any;

    qsirq_irq_vec #(.NQ(NQ)) u_irq (
        .rsp_stat (rspq_stat),
        .rsp_msk  (s_q.mask[RSP_LSB +: NQ]),
        .req_stat (reqq_stat),
        .req_msk  (s_q.mask[REQ_LSB +: NQ]),
        .err_any  (|err_bits),
        .err_msk  (s_q.mask[CMD_SAE]),
        .nonq     (nonq_stat),
        .nonq_msk (s_q.mask[CMD_NONQ]),
        .irq_any  (irq_any)
    );

    // read mux
    logic [DW-1:0] cmd_word;
    logic [DW-1:0] rd_mux;

    always_comb begin
        cmd_word                 = '0;
        cmd_word[RSP_LSB +: NQ]  = rspq_stat;
        cmd_word[REQ_LSB +: NQ]  = reqq_stat;
        cmd_word[CMD_SAE]        = |err_bits;
        cmd_word[CMD_PEND]       = s_q.irq;
        cmd_word[CMD_NONQ]       = nonq_stat;
        cmd_word[CMD_IDLE]       = idle_stat;

        rd_mux = '0;
        if (hit_cfg) begin
            rd_mux = DW'(cfg);
        end else if (hit_err) begin
            rd_mux = DW'(err_bits);
        end else if (hit_cmd) begin
            rd_mux = cmd_word;
        end else if (hit_msk) begin
            rd_mux = s_q.mask;
        end
    end

    // next state
    always_comb begin
        s_d        = s_q;
        s_d.rvalid = reg_rd;
        if (reg_rd) begin
            s_d.rdata = rd_mux;
        end
        s_d.srst = reg_wr && hit_cmd && reg_wdata[CMD_SRST] && !s_q.srst;
        if (reg_wr && hit_msk) begin
            s_d.mask = reg_wdata & MASK_WR;
        end
        if (s_q.srst) begin
            s_d.mask = '0;
        end
        s_d.irq = irq_any;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // view of the enable word for the bound checker
    logic [DW-1:0] mask_cur;
    assign mask_cur = s_q.mask;

    assign reg_rdata      = s_q.rdata;
    assign reg_rvalid     = s_q.rvalid;
    assign irq            = s_q.irq;
    assign soft_rst_pulse = s_q.srst;
    assign cfg_burst      = cfg.burst;
    assign cfg_enh_mode   = cfg.enh_mode;
    assign cfg_par_check  = cfg.par_check;
    assign cfg_par_test   = cfg.par_test;

endmodule

// File: rtl/qsirq_regblk_chk.sv
module qsirq_regblk_chk
    import qsirq_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_rdata,
    input logic              reg_rvalid,
    input logic              irq,
    input logic              soft_rst_pulse,
    input logic [DW-1:0]     mask_q,
    input logic [NERR-1:0]   err_q
);

    logic err_wr;
    logic cfg_rd;

    assign err_wr = reg_wr && (reg_addr == ADDR_W'(IDX_ERR * 4));
    assign cfg_rd = reg_rd && (reg_addr == ADDR_W'(IDX_CFG * 4));

    a_r2_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid);

    a_r2_rvalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> !reg_rvalid);

    a_r3_cfg_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd |=> (reg_rdata[31:CFG_W] == '0));

    a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst_pulse && !err_wr) |=> ((err_q & $past(err_q)) == $past(err_q)));

    a_r8_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |=> !irq);

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_pulse |=> !soft_rst_pulse);

    a_r10_pulse_clears: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_pulse |=> ((mask_q == '0) && (err_q == '0)));

endmodule

bind qsirq_regblk qsirq_regblk_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_rd         (reg_rd),
    .reg_wr         (reg_wr),
    .reg_addr       (reg_addr),
    .reg_rdata      (reg_rdata),
    .reg_rvalid     (reg_rvalid),
    .irq            (irq),
    .soft_rst_pulse (soft_rst_pulse),
    .mask_q         (mask_cur),
    .err_q          (err_bits)
);

// File: tb/qsirq_regblk_tb.sv
module qsirq_regblk_tb;

    localparam int ADDR_W = 4;
    localparam int NQ     = 4;
    localparam int WD_CYC = 100000;

    localparam logic [3:0] A_CFG = 4'h0;
    localparam logic [3:0] A_ERR = 4'h4;
    localparam logic [3:0] A_CMD = 4'h8;
    localparam logic [3:0] A_MSK = 4'hC;
    localparam logic [31:0] MSK_WR = 32'h000F_0F84;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic              reg_rd = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              reg_rvalid;
    logic [NQ-1:0]     rspq_stat = '0;
    logic [NQ-1:0]     reqq_stat = '1;
    logic              nonq_stat = 1'b0;
    logic              idle_stat = 1'b0;
    logic              err_align = 1'b0;
    logic              err_unsup = 1'b0;
    logic              err_parity = 1'b0;
    logic              irq;
    logic              soft_rst_pulse;
    logic [2:0]        cfg_burst;
    logic              cfg_enh_mode;
    logic              cfg_par_check;
    logic              cfg_par_test;

    always #10 clk = ~clk;

    qsirq_regblk #(.ADDR_W(ADDR_W), .NQ(NQ)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .rspq_stat(rspq_stat), .reqq_stat(reqq_stat),
        .nonq_stat(nonq_stat), .idle_stat(idle_stat), .err_align(err_align),
        .err_unsup(err_unsup), .err_parity(err_parity), .irq(irq),
        .soft_rst_pulse(soft_rst_pulse), .cfg_burst(cfg_burst),
        .cfg_enh_mode(cfg_enh_mode), .cfg_par_check(cfg_par_check),
        .cfg_par_test(cfg_par_test)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model
    logic [31:0] m_cfg  = '0;
    logic [2:0]  m_err  = '0;
    logic [31:0] m_mask = '0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic m_irq();
        logic v;
        v = |((rspq_stat & m_mask[19:16]) | (~reqq_stat & m_mask[11:8]));
        v = v | ((|m_err) & m_mask[7]) | (nonq_stat & m_mask[2]);
        return v;
    endfunction

    function automatic logic [31:0] m_cmd();
        logic [31:0] w;
        w        = '0;
        w[19:16] = rspq_stat;
        w[11:8]  = reqq_stat;
        w[7]     = |m_err;
        w[3]     = m_irq();
        w[2]     = nonq_stat;
        w[1]     = idle_stat;
        return w;
    endfunction

    function automatic logic [31:0] m_read(input logic [3:0] a);
        case (a)
            A_CFG:   return m_cfg;
            A_ERR:   return {29'd0, m_err};
            A_CMD:   return m_cmd();
            A_MSK:   return m_mask;
            default: return 32'd0;
        endcase
    endfunction

    // all tasks start and end on a falling edge
    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
        if (a == A_CFG) begin
            m_cfg[5:3] = d[5:3];
            if (d[2:0] == 3'd0 || d[2:0] == 3'd4 || d[2:0] == 3'd5 || d[2:0] == 3'd6)
                m_cfg[2:0] = d[2:0];
        end else if (a == A_ERR) begin
            m_err = m_err & ~d[2:0];
        end else if (a == A_MSK) begin
            m_mask = d & MSK_WR;
        end
    endtask

    // scoreboard driver: push expected item, issue strobe
    task automatic bus_read(input logic [3:0] a, input string tag);
        @(negedge clk);
        exp_q.push_back(m_read(a));
        tag_q.push_back(tag);
        reg_rd   = 1'b1;
        reg_addr = a;
        @(negedge clk);
        reg_rd   = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && reg_rvalid) begin
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R2 unexpected read data actual=%h expected=none", reg_rdata);
            end else begin
                chk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe_err(input int b);
        case (b)
            0: err_parity = 1'b1;
            1: err_unsup  = 1'b1;
            default: err_align = 1'b1;
        endcase
        @(negedge clk);
        err_parity = 1'b0;
        err_unsup  = 1'b0;
        err_align  = 1'b0;
        m_err[b]   = 1'b1;
    endtask

    task automatic chk_irq(input string tag);
        chk(tag, {31'd0, irq}, {31'd0, m_irq()});
    endtask

    task automatic finish_run();
        idle(3);
        chk("R2 scoreboard drained", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq", irq, 0);
        chk("R1 soft_rst_pulse", soft_rst_pulse, 0);
        chk("R1 rvalid", reg_rvalid, 0);
        chk("R1 cfg outputs", {cfg_par_test, cfg_par_check, cfg_enh_mode, cfg_burst}, 0);
        bus_read(A_CFG, "R1 cfg");
        bus_read(A_ERR, "R1 err");
        bus_read(A_MSK, "R1 mask");
        bus_read(A_CMD, "R1 cmd");

        // R3: configuration fields and upper bits
        bus_write(A_CFG, 32'hFFFF_FFF5);
        chk("R3 cfg outputs", {cfg_par_test, cfg_par_check, cfg_enh_mode, cfg_burst}, 6'h35);
        bus_read(A_CFG, "R3 cfg read");

        // R4: burst code legality
        bus_write(A_CFG, 32'h0000_0003);
        chk("R4 illegal 3 keeps burst", {cfg_par_test, cfg_par_check, cfg_enh_mode, cfg_burst}, 6'h05);
        bus_write(A_CFG, 32'h0000_000E);
        chk("R4 burst 6 stored", {cfg_par_test, cfg_par_check, cfg_enh_mode, cfg_burst}, 6'h0E);
        bus_write(A_CFG, 32'h0000_0017);
        chk("R4 illegal 7 keeps burst", {cfg_par_test, cfg_par_check, cfg_enh_mode, cfg_burst}, 6'h16);
        bus_write(A_CFG, 32'h0000_0004);
        bus_read(A_CFG, "R4 burst 4 read");
        bus_write(A_CFG, 32'h0000_0000);
        bus_read(A_CFG, "R4 burst 0 read");

        // R2: misaligned access ignored and reads zero
        bus_write(4'h1, 32'hFFFF_FFFF);
        bus_read(A_CFG, "R2 misaligned write ignored");
        bus_read(4'h9, "R2 misaligned read zero");

        // R7: enable word writable bits
        bus_write(A_MSK, 32'hFFFF_FFFF);
        bus_read(A_MSK, "R7 mask all ones");
        bus_write(A_MSK, 32'h0000_0000);

        // R6: command/status layout
        rspq_stat = 4'b0101;
        reqq_stat = 4'b1110;
        nonq_stat = 1'b1;
        idle_stat = 1'b1;
        idle(2);
        chk("R8 irq with no enables", irq, 0);
        bus_read(A_CMD, "R6 cmd layout");

        // R8: response queue enable, two-edge latency from write
        bus_write(A_MSK, 32'h0004_0000);
        chk("R8 irq not yet after mask write", irq, 0);
        @(negedge clk);
        chk_irq("R8 rsp2 irq");
        bus_read(A_CMD, "R8 pending bit");
        bus_write(A_MSK, 32'h0002_0000);
        @(negedge clk);
        chk_irq("R9 rsp1 clear no irq");
        rspq_stat = 4'b0111;
        @(negedge clk);
        chk_irq("R9 rsp1 set irq");

        // R9: request queue inverted polarity
        rspq_stat = 4'b0000;
        bus_write(A_MSK, 32'h0000_0100);
        @(negedge clk);
        chk_irq("R9 req0 clear raises irq");
        reqq_stat = 4'b1111;
        @(negedge clk);
        chk_irq("R9 req0 set drops irq");
        bus_write(A_MSK, 32'h0000_0800);
        @(negedge clk);
        chk_irq("R9 req3 set no irq");
        reqq_stat = 4'b0111;
        @(negedge clk);
        chk_irq("R9 req3 clear irq");
        reqq_stat = 4'b1111;

        // R8: non-queued source
        bus_write(A_MSK, 32'h0000_0004);
        @(negedge clk);
        chk_irq("R8 nonq irq");
        nonq_stat = 1'b0;
        @(negedge clk);
        chk_irq("R8 nonq low");

        // R5: sticky errors
        strobe_err(0);
        bus_read(A_ERR, "R5 parity set");
        strobe_err(2);
        idle(4);
        bus_read(A_ERR, "R5 sticky align+parity");
        bus_read(A_CMD, "R6 error summary bit");
        bus_write(A_ERR, 32'h0000_0001);
        bus_read(A_ERR, "R5 w1c parity");
        err_parity = 1'b1;
        bus_write(A_ERR, 32'h0000_0001);
        err_parity = 1'b0;
        m_err[0] = 1'b1;
        bus_read(A_ERR, "R5 set beats clear");
        bus_write(A_MSK, 32'h0000_0080);
        @(negedge clk);
        chk_irq("R8 error irq");
        bus_write(A_ERR, 32'h0000_0007);
        @(negedge clk);
        chk_irq("R8 error cleared irq");
        bus_read(A_ERR, "R5 all cleared");

        // R11: writes to status bits ignored
        bus_write(A_MSK, 32'h0000_0084);
        bus_write(A_CMD, 32'hFFFF_FFFE);
        chk("R11 no pulse", soft_rst_pulse, 0);
        bus_read(A_MSK, "R11 mask unchanged");
        bus_read(A_CMD, "R11 cmd unchanged");

        // R10: soft reset
        bus_write(A_CFG, 32'h0000_002D);
        bus_write(A_MSK, 32'h000F_0F84);
        strobe_err(1);
        strobe_err(0);
        bus_write(A_CMD, 32'h0000_0001);
        chk("R10 pulse high", soft_rst_pulse, 1);
        @(negedge clk);
        chk("R10 pulse one cycle", soft_rst_pulse, 0);
        m_mask = '0;
        m_err  = '0;
        bus_read(A_MSK, "R10 mask cleared");
        bus_read(A_ERR, "R10 err cleared");
        bus_read(A_CFG, "R10 cfg kept");
        bus_write(A_MSK, 32'h0000_0084);
        bus_write(A_CMD, 32'h0000_0001);
        chk("R10 first pulse", soft_rst_pulse, 1);
        bus_write(A_MSK, 32'h0000_0004);
        m_mask = '0;
        chk("R10 pulse ends", soft_rst_pulse, 0);
        bus_read(A_MSK, "R10 clear beats write");
        bus_write(A_MSK, 32'h0000_0084);
        bus_write(A_CMD, 32'h0000_0001);
        bus_write(A_CMD, 32'h0000_0001);
        m_mask = '0;
        chk("R10 request during pulse ignored", soft_rst_pulse, 0);

        done = 1;
        finish_run();
    end

endmodule